// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block models a small synchronous static RAM with a registered read path and single-cycle deselect. It is meant to sit in a chip as the cycle-exact model of a burst memory that a processor or a memory controller drives directly. At every rising clock edge it samples the chip selects, two address strobes, the advance input, the write controls, the address and, on writes, the data bus. It then classifies the cycle as a deselect, a snooze, the start of a burst, a burst advance or a burst suspend.

A burst begins at an external address. The two low address bits then step through a group of four, in either an XOR (interleaved) order or a linear order. Each edge of a burst performs a read or a write on the address it selects. Reads reach the bidirectional data bus through an output register. The output enable and the snooze input act on the bus without waiting for a clock edge.

Top module: `burst_sram`

## Requirements
- R1: After reset the data bus is high-Z and no burst is open. A cycle with both strobes high and the advance input low then gives high-Z on the bus.
- R2: A read sampled at a clock edge puts the addressed word on the bus after that same edge and holds it until the next edge. The bus is never combinational from the address.
- R3: When the processor strobe is low with the chip selected and snooze low, the cycle always starts a read at the external address. All write inputs and the controller strobe are ignored, so the memory is unchanged.
- R4: When the processor strobe is high and the controller strobe is low with the chip selected, a burst starts at the external address. The cycle is a read or a write according to the write decode of that same cycle, and write data is taken from the bus at that edge.
- R5: Write decode. Global write low writes all lanes. Otherwise lane-write low together with lane enable i low writes lane i, which is bus bits [9i+8:9i] with bit 9i+8 as that lane's parity bit. Lanes whose enable is high keep their contents. If lane-write is high, or all lane enables are high, and global write is high, the cycle is a read.
- R6: While a burst is open, a cycle with both strobes high and the advance input low steps a 2-bit count c. The upper address bits stay fixed. The low two bits are start XOR c when linear_order is 0, and (start + c) mod 4 when it is 1, so the count wraps inside the aligned group of four.
- R7: While a burst is open, a cycle with both strobes high and the advance input high repeats the read or write on the current address. The count does not change. This also lets a write follow a processor-strobe read on the next edge.
- R8: A cycle with either strobe low while the chip is not selected (en_a_n high, en_b low or en_c_n high) is a deselect. The bus is high-Z after that edge, nothing is written, and the burst closes.
- R9: While snooze is high the bus is high-Z at once. The edge performs no operation and closes the burst.
- R10: While oe_n is high the bus is high-Z at once. When oe_n returns low, the registered read data is driven again.
- R11: After an edge that performs a write, the bus is high-Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_a_n | input | 1 | Chip select, active low |
| en_b | input | 1 | Chip select, active high |
| en_c_n | input | 1 | Chip select, active low |
| sleep | input | 1 | Snooze request, active high |
| cpu_strobe_n | input | 1 | Processor address strobe, always reads |
| ctl_strobe_n | input | 1 | Controller address strobe, reads or writes |
| adv_n | input | 1 | Burst advance, low steps the count |
| all_wr_n | input | 1 | Global write, all lanes |
| lane_wr_n | input | 1 | Lane write qualifier |
| lane_en_n | input | LANES | Per-lane write enables |
| linear_order | input | 1 | Burst order: 0 interleaved, 1 linear |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Word address |
| dq | inout | 9*LANES | Data with parity bits |

## Verification
On every clock, the assertions check how the cycle kind maps to the next state. A processor-strobe start must load the read register. Deselect, snooze and write edges must leave it empty. A suspend must hold the burst count, and an advance must step it by one. Only the bench scenarios can show the values that appear on the bus: the data in both burst orders from every start address, the effect of byte-lane masks on memory contents, and the fact that ignored write inputs leave the memory intact. The same holds for the immediate high-Z effect of the output enable and snooze.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int LANES  = 2,
  parameter int ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_a_n,
  input  logic                  en_b,
  input  logic                  en_c_n,
  input  logic                  sleep,
  input  logic                  cpu_strobe_n,
  input  logic                  ctl_strobe_n,
  input  logic                  adv_n,
  input  logic                  all_wr_n,
  input  logic                  lane_wr_n,
  input  logic [LANES-1:0]      lane_en_n,
  input  logic                  linear_order,
  input  logic                  oe_n,
  input  logic [ADDR_W-1:0]     addr,
  inout  wire  [9*LANES-1:0]    dq
);
  localparam int LANE_W = 9;
  localparam int DW     = LANE_W * LANES;
  localparam int DEPTH  = 1 << ADDR_W;

  function automatic logic [1:0] step_lo(input logic [1:0] s, input logic [1:0] c, input logic lin);
    return lin ? 2'(s + c) : (s ^ c);
  endfunction

  logic              selected, begin_cpu, begin_ctl, start, desel, burst_step;
  logic              wr_dec, do_wr, do_rd;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] base_q, cur_addr;
  logic [1:0]        cnt_q, cnt_nxt;
  logic              active_q, q_vld;
  logic [DW-1:0]     q_q;
  logic [DW-1:0]     mem [DEPTH];

  assign selected   = !en_a_n && en_b && !en_c_n;
  assign begin_cpu  = !sleep && !cpu_strobe_n && selected;
  assign begin_ctl  = !sleep && cpu_strobe_n && !ctl_strobe_n && selected;
  assign start      = begin_cpu || begin_ctl;
  assign desel      = !sleep && (!cpu_strobe_n || !ctl_strobe_n) && !selected;
  assign burst_step = !sleep && cpu_strobe_n && ctl_strobe_n && active_q;

  assign lane_we = {LANES{!all_wr_n}} | ({LANES{!lane_wr_n}} & ~lane_en_n);
  assign wr_dec  = |lane_we;
  assign do_wr   = (begin_ctl || burst_step) && wr_dec;
  assign do_rd   = begin_cpu || ((begin_ctl || burst_step) && !wr_dec);

  assign cnt_nxt  = start ? 2'd0 : (burst_step && !adv_n) ? 2'(cnt_q + 2'd1) : cnt_q;
  assign cur_addr = start ? addr
                          : {base_q[ADDR_W-1:2], step_lo(base_q[1:0], cnt_nxt, linear_order)};

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (do_wr && lane_we[i])
        mem[cur_addr][i*LANE_W +: LANE_W] <= dq[i*LANE_W +: LANE_W];
    if (do_rd) q_q <= mem[cur_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= 2'd0;
      q_vld    <= 1'b0;
    end else begin
      if (start) begin
        active_q <= 1'b1;
        base_q   <= addr;
      end else if (desel || sleep) begin
        active_q <= 1'b0;
      end
      cnt_q <= cnt_nxt;
      q_vld <= do_rd;
    end
  end

  assign dq = (q_vld && !oe_n && !sleep) ? q_q : {DW{1'bz}};

  // R3
  cpu_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !cpu_strobe_n && !en_a_n && en_b && !en_c_n) |=> q_vld);

  // R8
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && (!cpu_strobe_n || !ctl_strobe_n) && (en_a_n || !en_b || en_c_n)) |=> (!q_vld && !active_q));

  // R9
  snooze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!q_vld && !active_q));

  // R11
  write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && cpu_strobe_n && !ctl_strobe_n && !en_a_n && en_b && !en_c_n && !all_wr_n) |=> !q_vld);

  // R7
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && cpu_strobe_n && ctl_strobe_n && adv_n && active_q) |=> $stable(cnt_q));

  // R6
  advance_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && cpu_strobe_n && ctl_strobe_n && !adv_n && active_q) |=> (cnt_q == 2'($past(cnt_q) + 2'd1)));
endmodule

// File: tb/burst_sram_bench.sv
`timescale 1ns/1ps
module burst_sram_bench;
  localparam int LANES = 2;
  localparam int AW    = 6;
  localparam int DW    = 9 * LANES;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic en_a_n, en_b, en_c_n, sleep, cpu_n, ctl_n, adv_n, gw_n, bwe_n, lin, oe_n;
  logic [LANES-1:0] be_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] tb_dq;
  logic tb_drv = 0;
  wire  [DW-1:0] dq;
  assign dq = tb_drv ? tb_dq : {DW{1'bz}};

  int total = 0, bad = 0;
  bit done = 0;
  logic [DW-1:0] exp_mem [DEPTH];

  burst_sram #(.LANES(LANES), .ADDR_W(AW)) u_burst_sram (
    .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .sleep(sleep), .cpu_strobe_n(cpu_n), .ctl_strobe_n(ctl_n), .adv_n(adv_n),
    .all_wr_n(gw_n), .lane_wr_n(bwe_n), .lane_en_n(be_n), .linear_order(lin),
    .oe_n(oe_n), .addr(addr), .dq(dq));

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 1237 + 4099) ^ DW'(a << 11);
  endfunction

  function automatic logic [1:0] ord(input logic [1:0] s, input int k, input logic l);
    return l ? 2'(s + 2'(k)) : (s ^ 2'(k));
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n, input logic [LANES-1:0] m);
    logic [DW-1:0] r = o;
    for (int i = 0; i < LANES; i++) if (m[i]) r[i*9 +: 9] = n[i*9 +: 9];
    return r;
  endfunction

  task automatic chk(input string rq, input logic [DW-1:0] exp);
    total++;
    if (dq !== exp) begin
      bad++;
      $display("FAIL %s: dq=%h expected=%h", rq, dq, exp);
    end
  endtask

  task automatic chk_z(input string rq);
    chk(rq, {DW{1'bz}});
  endtask

  task automatic quiet();
    en_a_n = 0; en_b = 1; en_c_n = 0; sleep = 0; cpu_n = 1; ctl_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; be_n = '1; oe_n = 0; tb_drv = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    tb_drv = 0; oe_n = 0;
    #1;
  endtask

  task automatic rd_cpu(input logic [AW-1:0] a);
    quiet(); cpu_n = 0; addr = a; tick();
  endtask

  task automatic rd_ctl(input logic [AW-1:0] a);
    quiet(); ctl_n = 0; addr = a; tick();
  endtask

  task automatic wr_ctl(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic g, input logic b, input logic [LANES-1:0] e);
    quiet(); ctl_n = 0; addr = a; gw_n = g; bwe_n = b; be_n = e;
    tb_dq = d; tb_drv = 1; oe_n = 1; tick();
  endtask

  task automatic cont();
    quiet(); adv_n = 0; tick();
  endtask

  task automatic susp();
    quiet(); tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    quiet(); lin = 0; addr = '0; tb_dq = '0;
    #1;
    // R1 bus released while in reset
    chk_z("R1");
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk_z("R1");
    cont();
    chk_z("R1");

    // Fill memory; R11 bus idle after each write
    for (int a = 0; a < DEPTH; a++) begin
      wr_ctl(AW'(a), pat(a), 1'b0, 1'b1, '1);
      exp_mem[a] = pat(a);
      chk_z("R11");
    end

    // R2 R6 full sweep of start addresses in both orders
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < DEPTH; s++) begin
        lin = 1'(m);
        rd_cpu(AW'(s));
        chk("R2", exp_mem[s]);
        for (int k = 1; k < 4; k++) begin
          lin = 1'(m);
          cont();
          chk("R6", exp_mem[{AW'(s) >> 2, ord(2'(s), k, 1'(m))}]);
        end
      end
    end
    lin = 0;

    // R5 lane-masked writes, including read-decoded masks
    for (int a = 0; a < 16; a++) begin
      for (int m = 0; m < (1 << LANES); m++) begin
        logic [DW-1:0] nd = pat(a + m * 16 + 100);
        wr_ctl(AW'(a), nd, 1'b1, 1'b0, ~LANES'(m));
        if (m == 0) chk("R5", exp_mem[a]);
        else chk_z("R5");
        exp_mem[a] = merge(exp_mem[a], nd, LANES'(m));
        rd_cpu(AW'(a));
        chk("R5", exp_mem[a]);
      end
      wr_ctl(AW'(a), ~exp_mem[a], 1'b1, 1'b1, '0);
      chk("R5", exp_mem[a]);
      rd_cpu(AW'(a));
      chk("R5", exp_mem[a]);
      wr_ctl(AW'(a), pat(a + 500), 1'b0, 1'b1, '1);
      exp_mem[a] = pat(a + 500);
      rd_cpu(AW'(a));
      chk("R5", exp_mem[a]);
    end

    // R3 processor strobe ignores writes and controller strobe
    quiet(); cpu_n = 0; ctl_n = 0; gw_n = 0; addr = 20; tb_dq = ~exp_mem[20]; tb_drv = 1; tick();
    chk("R3", exp_mem[20]);
    rd_cpu(20);
    chk("R3", exp_mem[20]);
    // R7 write on the following edge through suspend
    quiet(); gw_n = 0; tb_dq = pat(777); tb_drv = 1; oe_n = 1; tick();
    exp_mem[20] = pat(777);
    chk_z("R7");
    rd_cpu(20);
    chk("R7", exp_mem[20]);

    // R7 suspend repeats reads
    rd_cpu(8);
    chk("R7", exp_mem[8]);
    cont(); chk("R7", exp_mem[9]);
    susp(); chk("R7", exp_mem[9]);
    susp(); chk("R7", exp_mem[9]);
    cont(); chk("R7", exp_mem[10]);

    // R4 controller strobe read
    rd_ctl(12);
    chk("R4", exp_mem[12]);
    cont(); chk("R4", exp_mem[13]);

    // R8 deselect
    rd_cpu(5);
    chk("R8", exp_mem[5]);
    quiet(); ctl_n = 0; en_a_n = 1; gw_n = 0; addr = 5; tb_dq = ~exp_mem[5]; tb_drv = 1; tick();
    chk_z("R8");
    cont(); chk_z("R8");
    rd_cpu(5); chk("R8", exp_mem[5]);
    quiet(); cpu_n = 0; en_b = 0; addr = 6; tick();
    chk_z("R8");

    // R9 snooze
    rd_cpu(6);
    chk("R9", exp_mem[6]);
    sleep = 1; #1;
    chk_z("R9");
    ctl_n = 0; gw_n = 0; addr = 6; tb_dq = ~exp_mem[6]; tb_drv = 1; tick();
    chk_z("R9");
    cont(); chk_z("R9");
    rd_cpu(6); chk("R9", exp_mem[6]);

    // R10 output enable
    rd_cpu(7);
    chk("R10", exp_mem[7]);
    oe_n = 1; #1; chk_z("R10");
    oe_n = 0; #1; chk("R10", exp_mem[7]);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule